// File: doc/BRIEF.md
# Predicated Vector Float-to-Unsigned Converter

This block takes a packed vector of IEEE 754 floating-point lanes and turns every selected lane into an unsigned integer, always truncating toward zero. A 3-bit class select picks the source precision (half, single or double) and the result width (16, 32 or 64 bits). Each lane is as wide as the larger of the two. A narrower source sits in the low bits of its lane. A narrower result is widened with zeros to fill the lane.

A predicate with one bit per vector byte decides which lanes take the new value. Lanes that are not selected pass the old destination contents through unchanged. Out-of-range values saturate, NaN gives zero, and negative values give zero. Two sticky-free flags report whether any selected lane was invalid or inexact. The conversion is combinational and is followed by one register stage. That stage is qualified by a valid input and produces a valid output.

Top module: `vfcvt_uint_pred`

## Requirements
- R1: `size_sel` selects the class. 0 is half→u16 in 16-bit lanes. 1 is half→u32 and 3 is single→u32, both in 32-bit lanes. 2 is half→u64, 4 is single→u64, 5 is double→u32 and 6 is double→u64, all in 64-bit lanes. Lane k occupies bits [k·W+W−1 : k·W].
- R2: A finite in-range input produces its integer part, with any fraction dropped (truncation toward zero).
- R3: When the source is narrower than the lane, only the low source-width bits of the lane are read, and the upper bits have no effect on the result.
- R4: When the result is narrower than the lane, the upper lane bits of the output are zero.
- R5: A lane is active when the predicate bit of its lowest byte (bit k·W/8) is 1, and the other predicate bits of that lane are ignored. An inactive lane outputs the old destination lane.
- R6: A negative input of magnitude below 1 gives 0 and raises inexact only. A negative input of magnitude 1 or more, and −infinity, give 0 and raise invalid.
- R7: A positive input at or above 2^N, for result width N, and +infinity, give all ones in the N result bits and raise invalid.
- R8: A NaN of any sign or payload gives 0 and raises invalid.
- R9: +0, −0 and subnormal inputs give 0. Zeros raise no flag, and subnormals raise inexact.
- R10: `flag_inexact` is the OR over active lanes of "nonzero fraction bits were discarded". `flag_invalid` is the OR over active lanes of the invalid conditions. Inactive lanes never set a flag.
- R11: When no lane is active, the output equals the old destination and both flags are 0.
- R12: Results appear one clock after `in_valid`, together with `out_valid`. While `in_valid` is low, the output and flag registers hold their values. Reset clears `out_valid`, `out_vec` and both flags.
- R13: Class code 7 is reserved. It outputs the old destination with both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input vector is valid this cycle |
| size_sel | input | 3 | Conversion class (see R1) |
| src_vec | input | VLEN | Source floating-point vector |
| old_dst | input | VLEN | Previous destination vector, kept in inactive lanes |
| pred | input | VLEN/8 | One predicate bit per vector byte |
| out_valid | output | 1 | Output vector is valid |
| out_vec | output | VLEN | Merged result vector |
| flag_invalid | output | 1 | Some active lane was NaN or out of range |
| flag_inexact | output | 1 | Some active lane discarded fraction bits |

## Verification
The bench uses the default VLEN of 128. This gives eight 16-bit lanes, four 32-bit lanes and two 64-bit lanes. With that size, every one of the 65536 half-precision encodings is streamed through each of the three half classes. The expected results come from real-number arithmetic. Upper lane bits and non-lowest predicate bits are random, and a rotating set of lanes is inactive. The single and double classes are covered by chosen edge values: the largest value below each power-of-two limit, the limit itself, infinities, NaN, subnormals and small negatives.

// File: rtl/fcvtu_pkg.sv
// Package: shared types for the vector float-to-unsigned converter.
// Holds the class, source-format, result-width and lane-group encodings,
// the unpacked float field record, and the class decoder.
package fcvtu_pkg;

    typedef enum logic [2:0] {
        CLS_H_U16 = 3'd0,
        CLS_H_U32 = 3'd1,
        CLS_H_U64 = 3'd2,
        CLS_S_U32 = 3'd3,
        CLS_S_U64 = 3'd4,
        CLS_D_U32 = 3'd5,
        CLS_D_U64 = 3'd6,
        CLS_NONE  = 3'd7
    } cvt_class_e;

    typedef enum logic [1:0] {SRC_HALF, SRC_SINGLE, SRC_DOUBLE} src_fmt_e;
    typedef enum logic [1:0] {RES_16, RES_32, RES_64} res_width_e;
    typedef enum logic [1:0] {GRP_16, GRP_32, GRP_64, GRP_NONE} lane_grp_e;

    // Unpacked float: exponent is unbiased two's complement, mantissa has the hidden one at bit 52
    typedef struct packed {
        logic        sign;
        logic        is_nan;
        logic        is_inf;
        logic        is_zero;
        logic        is_sub;
        logic [12:0] exp;
        logic [52:0] mant;
    } fp_fields_t;

    typedef struct packed {
        src_fmt_e   fmt;
        res_width_e rw;
        lane_grp_e  grp;
    } class_decode_t;

    // Map a class code to source format, result width and lane group
    function automatic class_decode_t decode_class(input logic [2:0] code);
        class_decode_t d;
        case (cvt_class_e'(code))
            CLS_H_U16: d = '{SRC_HALF,   RES_16, GRP_16};
            CLS_H_U32: d = '{SRC_HALF,   RES_32, GRP_32};
            CLS_H_U64: d = '{SRC_HALF,   RES_64, GRP_64};
            CLS_S_U32: d = '{SRC_SINGLE, RES_32, GRP_32};
            CLS_S_U64: d = '{SRC_SINGLE, RES_64, GRP_64};
            CLS_D_U32: d = '{SRC_DOUBLE, RES_32, GRP_64};
            CLS_D_U64: d = '{SRC_DOUBLE, RES_64, GRP_64};
            default:   d = '{SRC_HALF,   RES_16, GRP_NONE};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fp_unpack.sv
// Module: fp_unpack
// Splits a raw half/single/double pattern (held in the low bits of a 64-bit
// word) into sign, class flags, unbiased exponent and a 53-bit mantissa with
// the fraction left-aligned under the hidden one.
// Assumes: bits above the selected format width are don't-care.
module fp_unpack
    import fcvtu_pkg::*;
(
    input  logic [63:0] raw,
    input  src_fmt_e    fmt,
    output fp_fields_t  fld
);
    logic [10:0] ex;
    logic [51:0] fr;
    logic [10:0] ex_max;
    logic [10:0] bias;

    // Select the fields of the chosen format
    always_comb begin
        case (fmt)
            SRC_HALF: begin
                fld.sign = raw[15];
                ex       = {6'b0, raw[14:10]};
                fr       = {raw[9:0], 42'b0};
                ex_max   = 11'h01F;
                bias     = 11'd15;
            end
            SRC_SINGLE: begin
                fld.sign = raw[31];
                ex       = {3'b0, raw[30:23]};
                fr       = {raw[22:0], 29'b0};
                ex_max   = 11'h0FF;
                bias     = 11'd127;
            end
            default: begin
                fld.sign = raw[63];
                ex       = raw[62:52];
                fr       = raw[51:0];
                ex_max   = 11'h7FF;
                bias     = 11'd1023;
            end
        endcase
    end

    // Classify the value and remove the exponent bias
    always_comb begin
        fld.is_nan  = (ex == ex_max) && (fr != '0);
        fld.is_inf  = (ex == ex_max) && (fr == '0);
        fld.is_zero = (ex == '0) && (fr == '0);
        fld.is_sub  = (ex == '0) && (fr != '0);
        fld.exp     = {2'b0, ex} - {2'b0, bias};
        fld.mant    = {1'b1, fr};
    end
endmodule

// File: rtl/fp_trunc_uint.sv
// Module: fp_trunc_uint
// Converts unpacked float fields to an unsigned integer of the selected
// result width, rounding toward zero, with saturation and flag generation.
// Assumes: OW is at least the width selected by rw.
module fp_trunc_uint
    import fcvtu_pkg::*;
#(
    parameter int OW = 64
) (
    input  fp_fields_t  fld,
    input  res_width_e  rw,
    output logic [OW-1:0] val,
    output logic        inv,
    output logic        inx
);
    logic [6:0]         rbits;
    logic [OW-1:0]      ones;
    logic signed [12:0] e;
    logic [5:0]         sh;
    logic [52:0]        lost_mask;
    logic [OW-1:0]      mag;
    logic               lost;

    // Result width in bits and its saturation value
    always_comb begin
        case (rw)
            RES_16:  begin rbits = 7'd16; ones = OW'(64'h0000_0000_0000_FFFF); end
            RES_32:  begin rbits = 7'd32; ones = OW'(64'h0000_0000_FFFF_FFFF); end
            default: begin rbits = 7'd64; ones = OW'(64'hFFFF_FFFF_FFFF_FFFF); end
        endcase
    end

    // Align the mantissa to the binary point and detect discarded fraction bits
    always_comb begin
        e         = $signed(fld.exp);
        sh        = '0;
        lost_mask = '0;
        mag       = '0;
        lost      = 1'b0;
        if (!e[12] && (e <= 13'sd52)) begin
            sh        = 6'd52 - e[5:0];
            mag       = OW'(fld.mant >> sh);
            lost_mask = (53'd1 << sh) - 53'd1;
            lost      = |(fld.mant & lost_mask);
        end else if (!e[12]) begin
            mag = OW'({11'b0, fld.mant} << (e[5:0] - 6'd52));
        end
    end

    // Pick the final value and flags by operand class and range
    always_comb begin
        val = '0;
        inv = 1'b0;
        inx = 1'b0;
        if (fld.is_nan) begin
            inv = 1'b1;
        end else if (fld.is_inf) begin
            inv = 1'b1;
            val = fld.sign ? '0 : ones;
        end else if (fld.is_zero) begin
            val = '0;
        end else if (fld.is_sub || e[12]) begin
            inx = 1'b1;
        end else if (e >= $signed({6'b0, rbits})) begin
            inv = 1'b1;
            val = fld.sign ? '0 : ones;
        end else if (fld.sign) begin
            inv = 1'b1;
        end else begin
            val = mag;
            inx = lost;
        end
    end
endmodule

// File: rtl/fcvt_lane.sv
// Module: fcvt_lane
// One lane converter of width LW: reads the source from the low bits of the
// lane, converts it and returns a zero-extended LW-bit result with flags.
// Assumes: the selected result width never exceeds LW.
module fcvt_lane
    import fcvtu_pkg::*;
#(
    parameter int LW = 64
) (
    input  logic [LW-1:0] lane_in,
    input  src_fmt_e      fmt,
    input  res_width_e    rw,
    output logic [LW-1:0] lane_out,
    output logic          inv,
    output logic          inx
);
    logic [63:0] raw;
    fp_fields_t  fld;

    // Present the lane contents to the unpacker as a 64-bit word
    always_comb raw = 64'(lane_in);

    fp_unpack u_unpack (
        .raw (raw),
        .fmt (fmt),
        .fld (fld)
    );

    fp_trunc_uint #(.OW(LW)) u_trunc (
        .fld (fld),
        .rw  (rw),
        .val (lane_out),
        .inv (inv),
        .inx (inx)
    );
endmodule

// File: rtl/vfcvt_uint_pred.sv
// Module: vfcvt_uint_pred
// Predicated vector float-to-unsigned converter. Builds converters for the
// 16-, 32- and 64-bit lane layouts, merges each with the old destination
// under the byte predicate, selects the layout of the chosen class and
// registers the result with a valid bit.
// Assumes: VLEN is a multiple of 64.
module vfcvt_uint_pred
    import fcvtu_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        size_sel,
    input  logic [VLEN-1:0]   src_vec,
    input  logic [VLEN-1:0]   old_dst,
    input  logic [VLEN/8-1:0] pred,
    output logic              out_valid,
    output logic [VLEN-1:0]   out_vec,
    output logic              flag_invalid,
    output logic              flag_inexact
);
    localparam int PW  = VLEN / 8;
    localparam int N16 = VLEN / 16;
    localparam int N32 = VLEN / 32;
    localparam int N64 = VLEN / 64;

    class_decode_t   dec;
    logic [VLEN-1:0] mrg16, mrg32, mrg64;
    logic [N16-1:0]  inv16, inx16;
    logic [N32-1:0]  inv32, inx32;
    logic [N64-1:0]  inv64, inx64;
    logic [VLEN-1:0] nxt_vec;
    logic            nxt_inv, nxt_inx;
    logic            pred_unused;

    // Decode the class select
    always_comb dec = decode_class(size_sel);

    // Only the lowest-byte predicate bit of each lane matters
    always_comb pred_unused = ^pred[PW-1:0];

    // 16-bit lane layout: half source, 16-bit result
    for (genvar gi = 0; gi < N16; gi++) begin : g_l16
        logic [15:0] res;
        logic        iv, ix;
        logic        act;
        fcvt_lane #(.LW(16)) u_lane (
            .lane_in  (src_vec[gi*16 +: 16]),
            .fmt      (SRC_HALF),
            .rw       (RES_16),
            .lane_out (res),
            .inv      (iv),
            .inx      (ix)
        );
        // Merge the converted lane with the old destination
        always_comb begin
            act                  = pred[gi*2];
            mrg16[gi*16 +: 16]   = act ? res : old_dst[gi*16 +: 16];
            inv16[gi]            = act & iv;
            inx16[gi]            = act & ix;
        end
    end

    // 32-bit lane layout: half or single source, 32-bit result
    for (genvar gi = 0; gi < N32; gi++) begin : g_l32
        logic [31:0] res;
        logic        iv, ix;
        logic        act;
        fcvt_lane #(.LW(32)) u_lane (
            .lane_in  (src_vec[gi*32 +: 32]),
            .fmt      (dec.fmt),
            .rw       (RES_32),
            .lane_out (res),
            .inv      (iv),
            .inx      (ix)
        );
        // Merge the converted lane with the old destination
        always_comb begin
            act                  = pred[gi*4];
            mrg32[gi*32 +: 32]   = act ? res : old_dst[gi*32 +: 32];
            inv32[gi]            = act & iv;
            inx32[gi]            = act & ix;
        end
    end

    // 64-bit lane layout: any source, 32- or 64-bit result
    for (genvar gi = 0; gi < N64; gi++) begin : g_l64
        logic [63:0] res;
        logic        iv, ix;
        logic        act;
        fcvt_lane #(.LW(64)) u_lane (
            .lane_in  (src_vec[gi*64 +: 64]),
            .fmt      (dec.fmt),
            .rw       (dec.rw),
            .lane_out (res),
            .inv      (iv),
            .inx      (ix)
        );
        // Merge the converted lane with the old destination
        always_comb begin
            act                  = pred[gi*8];
            mrg64[gi*64 +: 64]   = act ? res : old_dst[gi*64 +: 64];
            inv64[gi]            = act & iv;
            inx64[gi]            = act & ix;
        end
    end

    // Select the lane layout of the active class
    always_comb begin
        case (dec.grp)
            GRP_16: begin
                nxt_vec = mrg16;
                nxt_inv = |inv16;
                nxt_inx = |inx16;
            end
            GRP_32: begin
                nxt_vec = mrg32;
                nxt_inv = |inv32;
                nxt_inx = |inx32;
            end
            GRP_64: begin
                nxt_vec = mrg64;
                nxt_inv = |inv64;
                nxt_inx = |inx64;
            end
            default: begin
                nxt_vec = old_dst;
                nxt_inv = 1'b0;
                nxt_inx = 1'b0;
            end
        endcase
    end

    // Output register stage, loaded only on valid input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_vec      <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec      <= nxt_vec;
                flag_invalid <= nxt_inv;
                flag_inexact <= nxt_inx;
            end
        end
    end
endmodule

// File: rtl/fcvtu_checker.sv
// Module: fcvtu_checker
// Temporal checks on the converter's ports, bound into every instance.
module fcvtu_checker #(
    parameter int VLEN = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        size_sel,
    input logic [VLEN-1:0]   src_vec,
    input logic [VLEN-1:0]   old_dst,
    input logic [VLEN/8-1:0] pred,
    input logic              out_valid,
    input logic [VLEN-1:0]   out_vec,
    input logic              flag_invalid,
    input logic              flag_inexact
);
    // R12: out_valid is in_valid delayed by one clock
    p_valid_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R12: registers hold while no input is offered
    p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_vec) && $stable(flag_invalid) && $stable(flag_inexact)));

    // R11: an all-zero predicate returns the old destination with no flags
    p_no_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (pred == '0)) |=> ((out_vec == $past(old_dst)) && !flag_invalid && !flag_inexact));

    // R13: the reserved class leaves the destination unchanged
    p_reserved_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (size_sel == 3'd7)) |=> ((out_vec == $past(old_dst)) && !flag_invalid && !flag_inexact));

    // R9: an all-zero source raises no flag
    p_zero_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (src_vec == '0)) |=> (!flag_invalid && !flag_inexact));
endmodule

bind vfcvt_uint_pred fcvtu_checker #(.VLEN(VLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .size_sel     (size_sel),
    .src_vec      (src_vec),
    .old_dst      (old_dst),
    .pred         (pred),
    .out_valid    (out_valid),
    .out_vec      (out_vec),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact)
);

// File: tb/sim_vfcvt_uint_pred.sv
module sim_vfcvt_uint_pred;
    localparam int VLEN = 128;
    localparam int PW   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [2:0]      size_sel;
    logic [VLEN-1:0] src_vec;
    logic [VLEN-1:0] old_dst;
    logic [PW-1:0]   pred;
    logic            out_valid;
    logic [VLEN-1:0] out_vec;
    logic            flag_invalid;
    logic            flag_inexact;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vfcvt_uint_pred #(.VLEN(VLEN)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .size_sel     (size_sel),
        .src_vec      (src_vec),
        .old_dst      (old_dst),
        .pred         (pred),
        .out_valid    (out_valid),
        .out_vec      (out_vec),
        .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact)
    );

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference: half value to unsigned of rw bits, by real arithmetic
    task automatic half_ref(input logic [15:0] h, input int rw,
                            output logic [63:0] v, output logic inv, output logic inx);
        int  ex;
        int  fr;
        real mag;
        int  iv;
        ex  = int'(h[14:10]);
        fr  = int'(h[9:0]);
        v   = '0;
        inv = 1'b0;
        inx = 1'b0;
        if (ex == 31) begin
            inv = 1'b1;
            if (fr == 0 && !h[15])
                v = (rw == 64) ? '1 : ((64'd1 << rw) - 64'd1);
        end else begin
            if (ex == 0) mag = real'(fr) * (2.0 ** (-24));
            else         mag = real'(1024 + fr) * (2.0 ** (ex - 25));
            if (h[15]) begin
                if (mag >= 1.0) inv = 1'b1;
                else            inx = (mag != 0.0);
            end else if (mag >= 2.0 ** rw) begin
                inv = 1'b1;
                v   = (64'd1 << rw) - 64'd1;
            end else begin
                iv  = $rtoi(mag);
                v   = 64'(iv);
                inx = (real'(iv) != mag);
            end
        end
    endtask

    task automatic apply(input logic [2:0] cls, input logic [127:0] src,
                         input logic [127:0] old, input logic [PW-1:0] pr);
        in_valid = 1'b1;
        size_sel = cls;
        src_vec  = src;
        old_dst  = old;
        pred     = pr;
        @(negedge clk);
    endtask

    // Stream every half encoding through one half class
    task automatic sweep(input logic [2:0] cls, input int lw, input int rw, input string req);
        int lanes;
        int nb;
        logic [63:0] lmask;
        lanes = VLEN / lw;
        nb    = lw / 8;
        lmask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
        for (int base = 0; base < 65536; base += lanes) begin
            logic [127:0] src, old, expv;
            logic [PW-1:0] pr;
            logic einv, einx;
            old  = rnd128();
            src  = '0;
            expv = '0;
            pr   = '0;
            einv = 1'b0;
            einx = 1'b0;
            for (int l = 0; l < lanes; l++) begin
                logic [63:0] lane_src, r;
                logic i, x, act;
                lane_src = {$urandom, $urandom};
                lane_src = ((lane_src & ~64'hFFFF) | 64'(base + l)) & lmask;
                act = (((base / lanes) + l) % 5) != 0;
                for (int b = 0; b < nb; b++)
                    pr[l*nb + b] = (b == 0) ? act : 1'($urandom);
                half_ref(16'(base + l), rw, r, i, x);
                src = src | (128'(lane_src) << (l * lw));
                if (act) begin
                    expv = expv | (128'(r) << (l * lw));
                    einv = einv | i;
                    einx = einx | x;
                end else begin
                    expv = expv | (((old >> (l * lw)) & 128'(lmask)) << (l * lw));
                end
            end
            apply(cls, src, old, pr);
            check_eq(req, "vector", out_vec, expv);
            check_eq(req, "flags inv/inx", {126'b0, flag_invalid, flag_inexact}, {126'b0, einv, einx});
        end
    endtask

    // One value in lane 0, all lanes active
    task automatic dcase(input logic [2:0] cls, input logic [63:0] sv,
                         input logic [63:0] ev, input logic i, input logic x, input string req);
        apply(cls, {64'b0, sv}, rnd128(), '1);
        check_eq(req, "vector", out_vec, {64'b0, ev});
        check_eq(req, "flags inv/inx", {126'b0, flag_invalid, flag_inexact}, {126'b0, i, x});
    endtask

    initial begin
        logic [127:0] old, held;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        size_sel = '0;
        src_vec  = '0;
        old_dst  = '0;
        pred     = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        check_eq("R12", "reset out_valid", 128'(out_valid), 128'd0);
        check_eq("R12", "reset out_vec", out_vec, 128'd0);
        check_eq("R12", "reset flags", {126'b0, flag_invalid, flag_inexact}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R5 R6 R7 R8 R9 R10: every half pattern, half to u16
        sweep(3'd0, 16, 16, "R1/R2/R5/R6/R7/R8/R9/R10 h16");
        // R3 R4: half to u32 and u64 with random upper lane bits
        sweep(3'd1, 32, 32, "R1/R3/R4/R5/R10 h32");
        sweep(3'd2, 64, 64, "R1/R3/R4/R5/R10 h64");

        // R2 R7 R6 R8 R9: single to u32
        dcase(3'd3, 64'h4070_0000, 64'd3,             1'b0, 1'b1, "R2 s32 3.75");
        dcase(3'd3, 64'h4F7F_FFFF, 64'hFFFF_FF00,     1'b0, 1'b0, "R7 s32 below limit");
        dcase(3'd3, 64'h4F80_0000, 64'hFFFF_FFFF,     1'b1, 1'b0, "R7 s32 at limit");
        dcase(3'd3, 64'hBF80_0000, 64'd0,             1'b1, 1'b0, "R6 s32 -1");
        dcase(3'd3, 64'hBF00_0000, 64'd0,             1'b0, 1'b1, "R6 s32 -0.5");
        dcase(3'd3, 64'h7FC0_0000, 64'd0,             1'b1, 1'b0, "R8 s32 nan");
        dcase(3'd3, 64'h0000_0001, 64'd0,             1'b0, 1'b1, "R9 s32 subnormal");
        dcase(3'd3, 64'h8000_0000, 64'd0,             1'b0, 1'b0, "R9 s32 -0");
        // R3 R7: single to u64
        dcase(3'd4, 64'hFFFF_FFFF_4F80_0000, 64'h1_0000_0000, 1'b0, 1'b0, "R3 s64 2^32 upper ignored");
        dcase(3'd4, 64'h5F00_0000, 64'h8000_0000_0000_0000, 1'b0, 1'b0, "R2 s64 2^63");
        dcase(3'd4, 64'h5F80_0000, '1,                1'b1, 1'b0, "R7 s64 2^64");
        // R4 R7: double to u32
        dcase(3'd5, $realtobits(123456.789),   64'd123456,     1'b0, 1'b1, "R2 d32 fraction");
        dcase(3'd5, $realtobits(4294967295.0), 64'hFFFF_FFFF,  1'b0, 1'b0, "R4 d32 max");
        dcase(3'd5, $realtobits(4294967296.0), 64'hFFFF_FFFF,  1'b1, 1'b0, "R4/R7 d32 sat zero-extended");
        // R7 R6: double to u64
        dcase(3'd6, 64'h43EF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_F800, 1'b0, 1'b0, "R2 d64 below limit");
        dcase(3'd6, 64'h43F0_0000_0000_0000, '1,      1'b1, 1'b0, "R7 d64 2^64");
        dcase(3'd6, 64'h7FF0_0000_0000_0000, '1,      1'b1, 1'b0, "R7 d64 +inf");
        dcase(3'd6, 64'hFFF0_0000_0000_0000, 64'd0,   1'b1, 1'b0, "R6 d64 -inf");

        // R5: lane 0 lowest predicate bit clear, lane 1 only lowest bit set
        old = rnd128();
        apply(3'd6, {$realtobits(7.0), $realtobits(9.5)}, old, 16'h01FE);
        check_eq("R5", "lowest-byte predicate", out_vec, {64'd7, old[63:0]});
        check_eq("R5", "flags inv/inx", {126'b0, flag_invalid, flag_inexact}, 128'd0);

        // R11: no active lane
        old = rnd128();
        apply(3'd0, '1, old, '0);
        check_eq("R11", "no lane vector", out_vec, old);
        check_eq("R11", "no lane flags", {126'b0, flag_invalid, flag_inexact}, 128'd0);

        // R13: reserved class
        old = rnd128();
        apply(3'd7, '1, old, '1);
        check_eq("R13", "reserved vector", out_vec, old);
        check_eq("R13", "reserved flags", {126'b0, flag_invalid, flag_inexact}, 128'd0);
        check_eq("R12", "out_valid after input", 128'(out_valid), 128'd1);

        // R12: idle cycle holds the registers
        held = out_vec;
        in_valid = 1'b0;
        size_sel = 3'd0;
        src_vec  = '1;
        old_dst  = rnd128();
        pred     = '1;
        @(negedge clk);
        check_eq("R12", "idle out_valid", 128'(out_valid), 128'd0);
        check_eq("R12", "idle hold vector", out_vec, held);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule